// File: doc/BRIEF.md
# Supply Fault Reset Sequencer

This block is the digital core of a single-rail supply supervisor. Two analog comparators outside the block report whether the monitored rail is below its low threshold or above its high threshold. The block filters each comparator bit with an integrating counter, so that short spikes are rejected. It then drives two active-low fault outputs, one for undervoltage and one for overvoltage. Each output stays asserted for a programmable recovery time, counted in clock cycles, after its filtered fault has gone away.

The overvoltage output has a release control. While the control is low, a detected overvoltage is held until software or a board signal raises it. While it is high, the output recovers on its own, just as the undervoltage output does. Three more inputs change the behaviour. A supply-lockout flag forces undervoltage and suppresses overvoltage. A mute input silences both outputs for margining, though lockout still wins. A timer-skip strap removes the recovery time.

Top module: `supply_fault_seq`

## Requirements
- R1: While reset is applied both outputs are low (asserted). After reset is released, with no faults and the release control high, both outputs go high together TIMEOUT_CYC+2 clock edges after the edge at which reset is seen released: two edges for the reset synchronizer and TIMEOUT_CYC edges of recovery.
- R2: A comparator bit (1 = fault) must be high for FILT_LEVEL consecutive cycles, starting from a drained filter, to set the filtered fault. The output then falls FILT_LEVEL+1 edges after the bit rises. A pulse shorter than FILT_LEVEL cycles changes no output.
- R3: After a saturated undervoltage fault, uv_n_o rises FILT_LEVEL+TIMEOUT_CYC edges after uv_cmp_i falls: FILT_LEVEL edges to drain the filter and TIMEOUT_CYC edges with no fault.
- R4: If the undervoltage fault returns before the recovery time has elapsed, the timer is cleared. The output then rises only a full FILT_LEVEL+TIMEOUT_CYC edges after the last fall of uv_cmp_i.
- R5: The two outputs recover independently. Each one rises a recovery time after its own fault falls, whatever the other output is doing.
- R6: With ov_unlatch_i low, a detected overvoltage keeps ov_n_o low for as long as ov_unlatch_i stays low, even after the fault is gone. When ov_unlatch_i goes high and no recovery is pending, ov_n_o rises at the next edge.
- R7: With ov_unlatch_i high, ov_n_o recovers like uv_n_o. If ov_unlatch_i goes low while that recovery is running, ov_n_o stays low until ov_unlatch_i is high again.
- R8: One edge after lockout_i is sampled high, uv_n_o is low and ov_n_o is high. ov_n_o stays high for as long as lockout lasts, even when an overvoltage fault is present. When lockout ends, uv_n_o rises TIMEOUT_CYC edges later, and an overvoltage fault that is still present pulls ov_n_o low at the next edge.
- R9: While mute_i is high, both outputs are high whatever the comparator bits are. Lockout still pulls uv_n_o low at the next edge, and uv_n_o rises at the edge after lockout ends, with no recovery time. If mute_i falls while faults are present, the faulted outputs fall at the next edge.
- R10: With tmr_skip_i high, an output rises FILT_LEVEL+1 edges after its comparator bit falls. The fault then only has to drain through the filter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| uv_cmp_i | input | 1 | Raw undervoltage comparator, 1 = rail below low threshold |
| ov_cmp_i | input | 1 | Raw overvoltage comparator, 1 = rail above high threshold |
| lockout_i | input | 1 | Supervisor supply too low, 1 = lockout |
| ov_unlatch_i | input | 1 | 0 = overvoltage is sticky, 1 = clear and recover automatically |
| mute_i | input | 1 | 1 = silence both outputs (lockout still shows on uv_n_o) |
| tmr_skip_i | input | 1 | 1 = recovery time is zero |
| uv_n_o | output | 1 | Undervoltage fault, active low |
| ov_n_o | output | 1 | Overvoltage fault, active low |

## Verification
Lockout and the overvoltage path meet in one cycle when lockout_i rises while ov_n_o is held low by a live fault. Lockout and muting meet when lockout_i rises while mute_i is high. Both cases are provoked on purpose. Every output change is judged against an expected event queue stamped with the exact edge number, so in the first case a uv_n_o fall and an ov_n_o rise must appear on the same edge. The bench also checks that a release control dropped in the middle of a recovery period turns that recovery into a held overvoltage, with no early edge.

// File: rtl/supply_fault_pkg.sv
package supply_fault_pkg;
  localparam int unsigned CH_UV = 0;
  localparam int unsigned CH_OV = 1;
  localparam int unsigned NCH   = 2;

  // bits needed to hold the value maxval
  function automatic int unsigned bits_for(input int unsigned maxval);
    return (maxval < 2) ? 1 : $clog2(maxval + 1);
  endfunction
endpackage

// File: rtl/sfs_rst_sync.sv
module sfs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/sfs_integrator.sv
module sfs_integrator #(
  parameter int unsigned LEVEL = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic flt_o
);
  import supply_fault_pkg::*;
  localparam int unsigned CW = bits_for(LEVEL);
  localparam logic [CW-1:0] TOP = CW'(LEVEL);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          flt_q, flt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (raw_i && (cnt_q != TOP)) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end else if (!raw_i && (cnt_q != '0)) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
    flt_d = flt_q;
    if (cnt_d == TOP)     flt_d = 1'b1;
    else if (cnt_d == '0) flt_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      flt_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      flt_q <= flt_d;
    end
  end

  assign flt_o = flt_q;
endmodule

// File: rtl/sfs_hold_timer.sv
module sfs_hold_timer #(
  parameter int unsigned PERIOD = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond_i,
  input  logic clr_i,
  input  logic skip_i,
  output logic act_o,
  output logic act_nxt_o
);
  import supply_fault_pkg::*;
  localparam int unsigned TW = bits_for(PERIOD);
  localparam logic [TW-1:0] LAST = (PERIOD == 0) ? '0 : TW'(PERIOD - 1);
  localparam logic NO_WAIT = (PERIOD == 0);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    if (clr_i) begin
      act_d = 1'b0;
      cnt_d = '0;
    end else if (cond_i) begin
      act_d = 1'b1;
      cnt_d = '0;
    end else if (act_q) begin
      if (skip_i || NO_WAIT || (cnt_q == LAST)) begin
        act_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  // reset leaves the output held, recovery begins once reset lifts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  assign act_o     = act_q;
  assign act_nxt_o = act_d;
endmodule

// File: rtl/supply_fault_seq.sv
module supply_fault_seq #(
  parameter int unsigned FILT_LEVEL  = 4,
  parameter int unsigned TIMEOUT_CYC = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uv_cmp_i,
  input  logic ov_cmp_i,
  input  logic lockout_i,
  input  logic ov_unlatch_i,
  input  logic mute_i,
  input  logic tmr_skip_i,
  output logic uv_n_o,
  output logic ov_n_o
);
  import supply_fault_pkg::*;

  logic           rst_q_n;
  logic [NCH-1:0] raw_vec, flt_vec;
  logic           uv_cond, ov_cond;
  logic           uv_act, uv_act_d, ov_act, ov_act_d;
  logic           stuck_q, stuck_d;
  logic           uv_asrt_d, ov_asrt_d;
  logic           uv_n_q, ov_n_q;

  sfs_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  assign raw_vec[CH_UV] = uv_cmp_i;
  assign raw_vec[CH_OV] = ov_cmp_i;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_filt
    sfs_integrator #(.LEVEL(FILT_LEVEL)) u_int (
      .clk(clk), .rst_n(rst_q_n), .raw_i(raw_vec[ch]), .flt_o(flt_vec[ch])
    );
  end

  // lockout counts as an undervoltage and blocks overvoltage
  assign uv_cond = flt_vec[CH_UV] | lockout_i;
  assign ov_cond = flt_vec[CH_OV] & ~lockout_i;

  sfs_hold_timer #(.PERIOD(TIMEOUT_CYC)) u_uv_tmr (
    .clk(clk), .rst_n(rst_q_n), .cond_i(uv_cond), .clr_i(1'b0),
    .skip_i(tmr_skip_i), .act_o(uv_act), .act_nxt_o(uv_act_d)
  );

  sfs_hold_timer #(.PERIOD(TIMEOUT_CYC)) u_ov_tmr (
    .clk(clk), .rst_n(rst_q_n), .cond_i(ov_cond), .clr_i(lockout_i),
    .skip_i(tmr_skip_i), .act_o(ov_act), .act_nxt_o(ov_act_d)
  );

  // sticky overvoltage: captured while release control is low
  always_comb begin
    if (lockout_i || ov_unlatch_i) stuck_d = 1'b0;
    else                           stuck_d = stuck_q | ov_cond | ov_act;
  end

  always_comb begin
    uv_asrt_d = mute_i ? lockout_i : uv_act_d;
    ov_asrt_d = mute_i ? 1'b0      : (ov_act_d | stuck_d);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      stuck_q <= 1'b0;
      uv_n_q  <= 1'b0;
      ov_n_q  <= 1'b0;
    end else begin
      stuck_q <= stuck_d;
      uv_n_q  <= ~uv_asrt_d;
      ov_n_q  <= ~ov_asrt_d;
    end
  end

  assign uv_n_o = uv_n_q;
  assign ov_n_o = ov_n_q;
endmodule

// File: rtl/supply_fault_chk.sv
module supply_fault_chk (
  input logic clk,
  input logic rst_q_n,
  input logic lockout_i,
  input logic mute_i,
  input logic ov_unlatch_i,
  input logic uv_n_o,
  input logic ov_n_o
);
  assert_lock_uv_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    lockout_i |=> !uv_n_o);

  assert_lock_ov_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    lockout_i |=> ov_n_o);

  assert_mute_quiet_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mute_i && !lockout_i) |=> (uv_n_o && ov_n_o));

  assert_sticky_hold_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!ov_unlatch_i && !ov_n_o && !lockout_i && !mute_i) |=> !ov_n_o);
endmodule

bind supply_fault_seq supply_fault_chk u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .lockout_i(lockout_i), .mute_i(mute_i),
  .ov_unlatch_i(ov_unlatch_i), .uv_n_o(uv_n_o), .ov_n_o(ov_n_o)
);

// File: tb/tb_supply_fault_seq.sv
module tb_supply_fault_seq;
  localparam int CLK_PERIOD = 10;
  localparam int L = 4;
  localparam int P = 12;

  logic clk = 1'b0;
  logic rst_n, uv_cmp_i, ov_cmp_i, lockout_i, ov_unlatch_i, mute_i, tmr_skip_i;
  logic uv_n_o, ov_n_o;

  supply_fault_seq #(.FILT_LEVEL(L), .TIMEOUT_CYC(P)) dut (
    .clk(clk), .rst_n(rst_n), .uv_cmp_i(uv_cmp_i), .ov_cmp_i(ov_cmp_i),
    .lockout_i(lockout_i), .ov_unlatch_i(ov_unlatch_i), .mute_i(mute_i),
    .tmr_skip_i(tmr_skip_i), .uv_n_o(uv_n_o), .ov_n_o(ov_n_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int    sig;   // 0 = uv_n_o, 1 = ov_n_o
    bit    val;
    int    at;
    string req;
  } ev_t;

  ev_t   exp_q[$];
  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  bit    mon_on = 1'b0;
  bit    done = 1'b0;
  logic  uv_prev, ov_prev;
  string cur_req = "R1";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic push_ev(input int sig, input bit val, input int at, input string req);
    ev_t e;
    e.sig = sig; e.val = val; e.at = at; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic take(input int sig, input bit val);
    ev_t e;
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL %s: unexpected change of %s to %0b at edge %0d, expected no change",
               cur_req, sig ? "ov_n_o" : "uv_n_o", val, cyc);
    end else begin
      e = exp_q.pop_front();
      if (e.sig != sig || e.val != val || e.at != cyc) begin
        errors++;
        $display("FAIL %s: got %s=%0b at edge %0d, expected %s=%0b at edge %0d",
                 e.req, sig ? "ov_n_o" : "uv_n_o", val, cyc,
                 e.sig ? "ov_n_o" : "uv_n_o", e.val, e.at);
      end
    end
  endtask

  // monitor: every output change must match the head of the queue
  always @(negedge clk) begin
    if (mon_on) begin
      if (uv_n_o !== uv_prev) take(0, uv_n_o);
      if (ov_n_o !== ov_prev) take(1, ov_n_o);
    end
    uv_prev = uv_n_o;
    ov_prev = ov_n_o;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    ev_t e;
    while (exp_q.size() != 0) begin
      e = exp_q.pop_front();
      checks++;
      errors++;
      $display("FAIL %s: no change seen, expected %s=%0b at edge %0d (now %0d)",
               e.req, e.sig ? "ov_n_o" : "uv_n_o", e.val, e.at, cyc);
    end
  endtask

  task automatic check_lvl(input string req, input logic act, input logic expv, input string nm);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: %s actual %0b expected %0b", req, nm, act, expv);
    end
  endtask

  initial begin
    int c, d, d2;
    rst_n = 1'b0; uv_cmp_i = 1'b0; ov_cmp_i = 1'b0; lockout_i = 1'b0;
    ov_unlatch_i = 1'b1; mute_i = 1'b0; tmr_skip_i = 1'b0;
    step(3);
    // R1: reset state and first recovery
    check_lvl("R1", uv_n_o, 1'b0, "uv_n_o in reset");
    check_lvl("R1", ov_n_o, 1'b0, "ov_n_o in reset");
    mon_on = 1'b1;
    cur_req = "R1";
    rst_n = 1'b1; c = cyc;
    push_ev(0, 1'b1, c + P + 2, "R1");
    push_ev(1, 1'b1, c + P + 2, "R1");
    step(30); drain();

    // R2: glitch shorter than the filter level is ignored
    cur_req = "R2";
    uv_cmp_i = 1'b1; step(L - 1); uv_cmp_i = 1'b0;
    step(20); drain();
    check_lvl("R2", uv_n_o, 1'b1, "uv_n_o after short glitch");

    // R2/R3: fault exactly at the level, then timed recovery
    cur_req = "R3";
    uv_cmp_i = 1'b1; c = cyc;
    push_ev(0, 1'b0, c + L + 1, "R2");
    step(10);
    uv_cmp_i = 1'b0; d = cyc;
    push_ev(0, 1'b1, d + L + P, "R3");
    step(25); drain();

    // R4: fault returns during recovery, timer restarts
    cur_req = "R4";
    uv_cmp_i = 1'b1; c = cyc;
    push_ev(0, 1'b0, c + L + 1, "R4");
    step(8);
    uv_cmp_i = 1'b0; step(6);
    uv_cmp_i = 1'b1; step(6);
    uv_cmp_i = 1'b0; d2 = cyc;
    push_ev(0, 1'b1, d2 + L + P, "R4");
    step(25); drain();

    // R5/R7: independent channels, transparent overvoltage
    cur_req = "R5";
    uv_cmp_i = 1'b1; ov_cmp_i = 1'b1; c = cyc;
    push_ev(0, 1'b0, c + L + 1, "R5");
    push_ev(1, 1'b0, c + L + 1, "R5");
    step(8);
    uv_cmp_i = 1'b0; d = cyc;
    push_ev(0, 1'b1, d + L + P, "R5");
    step(5);
    ov_cmp_i = 1'b0; d2 = cyc;
    push_ev(1, 1'b1, d2 + L + P, "R7");
    step(30); drain();

    // R6: sticky overvoltage with release control low
    cur_req = "R6";
    ov_unlatch_i = 1'b0;
    ov_cmp_i = 1'b1; c = cyc;
    push_ev(1, 1'b0, c + L + 1, "R6");
    step(8);
    ov_cmp_i = 1'b0; step(30);
    check_lvl("R6", ov_n_o, 1'b0, "ov_n_o held while control low");
    ov_unlatch_i = 1'b1; c = cyc;
    push_ev(1, 1'b1, c + 1, "R6");
    step(5); drain();

    // R7: control falls during a running recovery
    cur_req = "R7";
    ov_cmp_i = 1'b1; c = cyc;
    push_ev(1, 1'b0, c + L + 1, "R7");
    step(8);
    ov_cmp_i = 1'b0; step(8);
    ov_unlatch_i = 1'b0; step(30);
    check_lvl("R7", ov_n_o, 1'b0, "ov_n_o latched mid-recovery");
    ov_unlatch_i = 1'b1; c = cyc;
    push_ev(1, 1'b1, c + 1, "R7");
    step(5); drain();

    // R8: lockout forces UV, clears and blocks OV in the same edge
    cur_req = "R8";
    ov_cmp_i = 1'b1; c = cyc;
    push_ev(1, 1'b0, c + L + 1, "R8");
    step(10);
    lockout_i = 1'b1; c = cyc;
    push_ev(0, 1'b0, c + 1, "R8");
    push_ev(1, 1'b1, c + 1, "R8");
    step(10);
    check_lvl("R8", ov_n_o, 1'b1, "ov_n_o blocked during lockout");
    lockout_i = 1'b0; d = cyc;
    push_ev(1, 1'b0, d + 1, "R8");
    push_ev(0, 1'b1, d + P, "R8");
    step(20);
    ov_cmp_i = 1'b0; d2 = cyc;
    push_ev(1, 1'b1, d2 + L + P, "R8");
    step(25); drain();

    // R9: mute, with lockout still shown on uv_n_o
    cur_req = "R9";
    mute_i = 1'b1; step(2);
    uv_cmp_i = 1'b1; ov_cmp_i = 1'b1; step(15);
    check_lvl("R9", uv_n_o, 1'b1, "uv_n_o muted");
    check_lvl("R9", ov_n_o, 1'b1, "ov_n_o muted");
    lockout_i = 1'b1; c = cyc;
    push_ev(0, 1'b0, c + 1, "R9");
    step(5);
    lockout_i = 1'b0; d = cyc;
    push_ev(0, 1'b1, d + 1, "R9");
    step(3);
    mute_i = 1'b0; c = cyc;
    push_ev(0, 1'b0, c + 1, "R9");
    push_ev(1, 1'b0, c + 1, "R9");
    step(5);
    uv_cmp_i = 1'b0; ov_cmp_i = 1'b0; d = cyc;
    push_ev(0, 1'b1, d + L + P, "R9");
    push_ev(1, 1'b1, d + L + P, "R9");
    step(25); drain();

    // R10: timer skip
    cur_req = "R10";
    tmr_skip_i = 1'b1;
    uv_cmp_i = 1'b1; c = cyc;
    push_ev(0, 1'b0, c + L + 1, "R10");
    step(8);
    uv_cmp_i = 1'b0; d = cyc;
    push_ev(0, 1'b1, d + L + 1, "R10");
    step(10);
    ov_cmp_i = 1'b1; c = cyc;
    push_ev(1, 1'b0, c + L + 1, "R10");
    step(8);
    ov_cmp_i = 1'b0; d = cyc;
    push_ev(1, 1'b1, d + L + 1, "R10");
    step(10); drain();
    tmr_skip_i = 1'b0;

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule